// File: doc/BRIEF.md
# Protection Region Address Matcher

This block decides whether one access address falls inside a single physical memory protection region. It receives the byte address of the access, the region's own address register, the address register of the region just below it, and a two-bit mode. It returns one match bit, registered, one clock cycle after the inputs are presented. A protection unit would place one instance per region and combine the match bits with permissions and priority elsewhere.

The address registers hold a word address: bit k of a register corresponds to byte address bit k+2, so the access address is shifted right by two before any comparison. The match is built from three-way comparison results (less, equal, greater). A mask, derived from the region register, is applied ahead of the upper comparator. This lets the same comparator serve the top-of-range test, the exact four-byte test and the naturally aligned power-of-two test. A parameter marks the lowest region, whose lower bound is zero.

Top module: `pmp_region_match`

## Requirements
- R1: Mode value 0 (off) never produces a match.
- R2: Mode value 1 (top of range) matches when the access word address is greater than or equal to the lower bound. The lower bound is the previous region register.
- R3: In mode value 1 the upper bound is exclusive: an access whose word address equals or exceeds the region register does not match.
- R4: In mode value 1, when the lower bound is greater than or equal to the region register, no address matches.
- R5: When the FIRST_ENTRY parameter is 1, the lower bound used in mode value 1 is zero, whatever the previous register holds.
- R6: Mode value 2 (four-byte region) matches exactly when access address bits above bit 1 equal the region register. Access bits 1 and 0 have no effect.
- R7: Mode value 3 (power-of-two region): let t be the number of consecutive ones in the region register counted from bit 0. Word-address bits t down to 0 are ignored. The access matches when the remaining higher bits equal those of the register.
- R8: In mode value 3, a region register of all ones matches every access address.
- R9: The match output is low while reset (active-low rstN) is asserted. Otherwise it reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accAddr | input | ADDR_W | Byte address of the access |
| regAddr | input | ADDR_W-2 | Region address register (word address) |
| prevAddr | input | ADDR_W-2 | Previous region's address register, lower bound in mode 1 |
| mode | input | 2 | Addressing mode: 0 off, 1 top of range, 2 four-byte, 3 power-of-two |
| hit | output | 1 | Registered match result |

## Verification
A six-bit address configuration is swept exhaustively: every access address, region register, previous register and mode. Two instances are driven in the sweep, one ordinary and one marked as the lowest region. In top-of-range mode the sweep includes equal bounds, reversed bounds and accesses exactly on each bound. This separates the inclusive lower bound from the exclusive upper bound, and shows the lowest region ignoring the previous register. In the power-of-two mode every trailing-ones count is covered, up to the all-ones register. A wrong mask width therefore shows up as a region of the wrong size. In four-byte mode, accesses that differ only in the two low byte bits must give identical results.

// File: rtl/pmp_match_pkg.sv
package pmp_match_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } regionMode_e;

  typedef enum logic [1:0] {
    CMP_LT = 2'd0,
    CMP_EQ = 2'd1,
    CMP_GT = 2'd2
  } cmpRes_e;

  typedef struct packed {
    logic torSel;
    logic eqSel;
    logic napotSel;
  } cmpStrobe_t;

endpackage

// File: rtl/pmp_word_cmp.sv
module pmp_word_cmp
  import pmp_match_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output cmpRes_e      res
);

  logic isLt;
  logic isGt;
  logic isEq;

  assign isLt = opA < opB;
  assign isGt = opA > opB;
  assign isEq = opA == opB;

  always_comb begin
    res = CMP_EQ;
    if (isLt)      res = CMP_LT;
    else if (isGt) res = CMP_GT;
    else if (isEq) res = CMP_EQ;
  end

endmodule

// File: rtl/pmp_match_ctrl.sv
module pmp_match_ctrl
  import pmp_match_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic [1:0]       mode,
  input  logic [REG_W-1:0] regAddr,
  output cmpStrobe_t       strb,
  output logic [REG_W-1:0] cmpMask
);

  regionMode_e modeSel;
  logic [REG_W-1:0] napotMask;

  assign modeSel = regionMode_e'(mode);

  // Bit i of the mask survives only if some register bit below i is zero.
  always_comb begin
    logic onesRun;
    onesRun = 1'b1;
    for (int i = 0; i < REG_W; i++) begin
      napotMask[i] = ~onesRun;
      onesRun      = onesRun & regAddr[i];
    end
  end

  always_comb begin
    strb = '0;
    unique case (modeSel)
      MODE_TOR:   strb.torSel = 1'b1;
      MODE_NA4:   strb.eqSel  = 1'b1;
      MODE_NAPOT: begin
        strb.eqSel    = 1'b1;
        strb.napotSel = 1'b1;
      end
      default:    strb = '0;
    endcase
  end

  assign cmpMask = strb.napotSel ? napotMask : {REG_W{1'b1}};

endmodule

// File: rtl/pmp_match_dp.sv
module pmp_match_dp
  import pmp_match_pkg::*;
#(
  parameter int REG_W       = 32,
  parameter bit FIRST_ENTRY = 1'b0
) (
  input  logic [REG_W-1:0] accWord,
  input  logic [REG_W-1:0] regAddr,
  input  logic [REG_W-1:0] prevAddr,
  input  cmpStrobe_t       strb,
  input  logic [REG_W-1:0] cmpMask,
  output logic             matchNext
);

  logic [REG_W-1:0] lowBound;
  cmpRes_e hiRes;
  cmpRes_e loRes;

  generate
    if (FIRST_ENTRY) begin : g_firstLow
      assign lowBound = '0;
      logic unusedPrev;
      assign unusedPrev = ^prevAddr;
    end else begin : g_prevLow
      assign lowBound = prevAddr;
    end
  endgenerate

  pmp_word_cmp #(.W(REG_W)) i_hiCmp (
    .opA (accWord & cmpMask),
    .opB (regAddr & cmpMask),
    .res (hiRes)
  );

  pmp_word_cmp #(.W(REG_W)) i_loCmp (
    .opA (accWord),
    .opB (lowBound),
    .res (loRes)
  );

  logic torHit;
  logic eqHit;

  assign torHit    = strb.torSel & (loRes != CMP_LT) & (hiRes == CMP_LT);
  assign eqHit     = strb.eqSel & (hiRes == CMP_EQ);
  assign matchNext = torHit | eqHit;

endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
  import pmp_match_pkg::*;
#(
  parameter int ADDR_W      = 34,
  parameter bit FIRST_ENTRY = 1'b0,
  localparam int REG_W      = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [REG_W-1:0]  regAddr,
  input  logic [REG_W-1:0]  prevAddr,
  input  logic [1:0]        mode,
  output logic              hit
);

  cmpStrobe_t strb;
  logic [REG_W-1:0] cmpMask;
  logic [REG_W-1:0] accWord;
  logic matchNext;
  logic [1:0] unusedLow;

  assign accWord   = accAddr[ADDR_W-1:2];
  assign unusedLow = accAddr[1:0];

  pmp_match_ctrl #(.REG_W(REG_W)) i_ctrl (
    .mode    (mode),
    .regAddr (regAddr),
    .strb    (strb),
    .cmpMask (cmpMask)
  );

  pmp_match_dp #(.REG_W(REG_W), .FIRST_ENTRY(FIRST_ENTRY)) i_dp (
    .accWord   (accWord),
    .regAddr   (regAddr),
    .prevAddr  (prevAddr),
    .strb      (strb),
    .cmpMask   (cmpMask),
    .matchNext (matchNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hit <= 1'b0;
    else       hit <= matchNext;
  end

endmodule

// File: rtl/pmp_match_checker.sv
module pmp_match_checker #(
  parameter int ADDR_W      = 34,
  parameter bit FIRST_ENTRY = 1'b0,
  localparam int REG_W      = ADDR_W - 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] accAddr,
  input logic [REG_W-1:0]  regAddr,
  input logic [REG_W-1:0]  prevAddr,
  input logic [1:0]        mode,
  input logic              hit
);

  logic [REG_W-1:0] accWord;
  assign accWord = accAddr[ADDR_W-1:2];

  AST_OFF_NEVER: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(mode) == 2'd0) |-> !hit); // R1

  AST_TOR_BELOW_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !FIRST_ENTRY && $past(mode) == 2'd1 &&
     $past(accWord) < $past(prevAddr)) |-> !hit); // R2

  AST_TOR_UPPER_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(mode) == 2'd1 && $past(accWord) >= $past(regAddr)) |-> !hit); // R3

  AST_NA4_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(mode) == 2'd2) |-> (hit == ($past(accWord) == $past(regAddr)))); // R6

  AST_NAPOT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(mode) == 2'd3 && $past(&regAddr)) |-> hit); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> !hit); // R9

endmodule

bind pmp_region_match pmp_match_checker #(
  .ADDR_W      (ADDR_W),
  .FIRST_ENTRY (FIRST_ENTRY)
) i_pmpMatchChk (
  .clk      (clk),
  .rstN     (rstN),
  .accAddr  (accAddr),
  .regAddr  (regAddr),
  .prevAddr (prevAddr),
  .mode     (mode),
  .hit      (hit)
);

// File: tb/test_pmp_region_match.sv
module test_pmp_region_match;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 6;
  localparam int REG_W      = ADDR_W - 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic [REG_W-1:0]  regAddr = '0;
  logic [REG_W-1:0]  prevAddr = '0;
  logic [1:0]        mode = '0;
  logic hit;
  logic hitFirst;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmp_region_match #(.ADDR_W(ADDR_W), .FIRST_ENTRY(1'b0)) i_pmp_region_match (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .regAddr(regAddr),
    .prevAddr(prevAddr), .mode(mode), .hit(hit)
  );

  pmp_region_match #(.ADDR_W(ADDR_W), .FIRST_ENTRY(1'b1)) i_pmp_region_match_first (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .regAddr(regAddr),
    .prevAddr(prevAddr), .mode(mode), .hit(hitFirst)
  );

  function automatic bit expHit(int m, int a, int r, int p, bit first);
    int w;
    int lo;
    int t;
    w  = a >> 2;
    lo = first ? 0 : p;
    case (m)
      1: return (lo <= w) && (w < r);
      2: return w == r;
      3: begin
        t = 0;
        while (t < REG_W && ((r >> t) & 1) == 1) t++;
        return (w >> (t + 1)) == (r >> (t + 1));
      end
      default: return 1'b0;
    endcase
  endfunction

  function automatic string reqTag(int m, int a, int r, int p, bit first);
    int w;
    w = a >> 2;
    case (m)
      0: return "R1";
      1: begin
        if (first) return "R5";
        if (p >= r) return "R4";
        if (w >= r) return "R3";
        return "R2";
      end
      2: return "R6";
      default: return (r == (1 << REG_W) - 1) ? "R8" : "R7";
    endcase
  endfunction

  task automatic check(string tag, bit actual, bit expected);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b mode=%0d acc=%0d reg=%0d prev=%0d",
               tag, actual, expected, mode, accAddr, regAddr, prevAddr);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: output held low during reset, even with a matching input pattern
    mode = 2'd3;
    regAddr = '1;
    repeat (3) @(posedge clk);
    #1;
    check("R9", hit, 1'b0);
    check("R9", hitFirst, 1'b0);
    @(negedge clk);
    rstN = 1'b1;

    // R9: the result appears one edge after the inputs change
    @(negedge clk);
    mode = 2'd0;
    @(posedge clk);
    #1;
    check("R9", hit, 1'b0);
    @(negedge clk);
    mode = 2'd3;
    #1;
    check("R9", hit, 1'b0);
    @(posedge clk);
    #1;
    check("R9", hit, 1'b1);

    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < (1 << REG_W); r++) begin
        for (int p = 0; p < (1 << REG_W); p++) begin
          for (int a = 0; a < (1 << ADDR_W); a++) begin
            @(negedge clk);
            mode     = 2'(m);
            regAddr  = REG_W'(r);
            prevAddr = REG_W'(p);
            accAddr  = ADDR_W'(a);
            @(posedge clk);
            #1;
            check(reqTag(m, a, r, p, 1'b0), hit, expHit(m, a, r, p, 1'b0));
            check(reqTag(m, a, r, p, 1'b1), hitFirst, expHit(m, a, r, p, 1'b1));
          end
        end
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule